// File: doc/BRIEF.md
# Orbit-Gated Bunch Occupancy Histogrammer

This block builds four per-bunch occupancy histograms over a fixed number of beam orbits. Each bunch crossing carries four class counts from an upstream threshold counter. An orbit marker restarts a bunch counter, and that counter names the bin that each crossing's counts are added to. Histogram k receives class count k.

The host uses two controls to fill. It sets a run level and a fill enable. Filling then starts at the next orbit marker, so every orbit is counted from its first crossing. After the configured number of full orbits the block stops by itself and raises a done flag. The flag stays high until the host drops the fill enable.

To read back, the host loads a bin number into the bin-address register and picks one of the four histograms with a select input. A clear command sweeps every bin to zero before a new run.

Top module: `orbit_histogrammer`

## Requirements
- R1: After reset, `done` and `clearing` are low, and no bin changes until both fill controls are set and an orbit marker arrives.
- R2: A crossing with `bc0` high has bunch number 0. Each later crossing without `bc0` has the previous number plus one. The number saturates at 2^BIN_W-1 (4095 by default) when no marker arrives.
- R3: Filling requires `run` and `fill_en` both high. It begins with the first `bc0` crossing seen after both are high. Crossings before that marker change no bin.
- R4: On each filled crossing, histogram k (k = 0..3) adds the class count in bits [k*CLASS_W +: CLASS_W] of `cls_cnt` to the bin equal to the crossing's bunch number.
- R5: A bin that would pass 2^CNT_W-1 (0xFFFF by default) holds at that value instead of wrapping.
- R6: Once ORBITS (1024 by default) full orbits have been filled, the next `bc0` crossing is not added. `done` rises on the following cycle and stays high while `fill_en` stays high. It falls on the cycle after `fill_en` drops.
- R7: If `run` or `fill_en` drops while the block is waiting for the first marker or is filling, filling stops at once and `done` stays low.
- R8: A one-cycle `clear_req`, accepted while idle or done, zeroes every bin at a rate of one address per cycle. `clearing` is high for exactly 2^BIN_W cycles. During the sweep `done` is low and crossings change no bin.
- R9: `bin_wr` loads `bin_in` into the bin-address register. `rd_data` shows the bin at that address in histogram `hist_sel` (0..3) in the same cycle.
- R10: A `clear_req` that arrives while the block is waiting for a marker or is filling is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xing | input | 1 | One bunch crossing this cycle |
| bc0 | input | 1 | Orbit marker, meaningful only together with `xing` |
| cls_cnt | input | 4*CLASS_W | Four class counts for this crossing |
| run | input | 1 | Run state level |
| fill_en | input | 1 | Fill-mode enable |
| clear_req | input | 1 | Pulse: zero all bins |
| bin_wr | input | 1 | Load the bin-address register |
| bin_in | input | BIN_W | Bin number to load |
| hist_sel | input | 2 | Histogram picked for readback |
| rd_data | output | CNT_W | Contents of the selected bin |
| done | output | 1 | Fill run complete |
| clearing | output | 1 | Clear sweep in progress |

## Verification
The stimulus uses orbits of different lengths, with and without idle gaps between crossings, and with class counts that differ from crossing to crossing. These patterns show whether bins are addressed by crossing number or by cycle number. One orbit is longer than the bin range. It drives the bunch counter into saturation and pushes the last bin past its 16-bit-style limit, which separates saturating bins from wrapping ones. Further runs do four things:
- enable filling in the middle of an orbit, which exposes a block that starts before the marker;
- run one orbit more than the limit, which exposes an off-by-one stop;
- abort a run mid-orbit;
- send a clear during a fill, which must be ignored.

A full readback sweep over every bin and every histogram follows each phase.

// File: rtl/hist_pkg.sv
package hist_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARM   = 3'd1,
    ST_FILL  = 3'd2,
    ST_DONE  = 3'd3,
    ST_CLEAR = 3'd4
  } fill_state_e;
endpackage

// File: rtl/hist_bunch_ctr.sv
module hist_bunch_ctr #(
  parameter int BIN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xing,
  input  logic             bc0,
  output logic [BIN_W-1:0] bx_q,
  output logic [BIN_W-1:0] bin_now
);
  localparam logic [BIN_W-1:0] BX_MAX = {BIN_W{1'b1}};

  logic [BIN_W-1:0] bx_d;

  always_comb begin
    if (bc0) begin
      bin_now = '0;
    end else if (bx_q == BX_MAX) begin
      bin_now = BX_MAX;
    end else begin
      bin_now = bx_q + 1'b1;
    end
    bx_d = xing ? bin_now : bx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bx_q <= '0;
    end else begin
      bx_q <= bx_d;
    end
  end
endmodule

// File: rtl/hist_fill_ctrl.sv
module hist_fill_ctrl
  import hist_pkg::*;
#(
  parameter int BIN_W  = 12,
  parameter int ORBITS = 1024
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            xing,
  input  logic                            bc0,
  input  logic                            run,
  input  logic                            fill_en,
  input  logic                            clear_req,
  output logic                            acc_en,
  output logic                            clr_en,
  output logic [BIN_W-1:0]                clr_addr,
  output logic                            done,
  output logic                            clearing,
  output logic [$clog2(ORBITS+1)-1:0]     orb_cnt
);
  localparam int ORB_W = $clog2(ORBITS + 1);
  localparam logic [ORB_W-1:0] ORB_LAST = ORB_W'(ORBITS);
  localparam logic [BIN_W-1:0] ADDR_MAX = {BIN_W{1'b1}};

  fill_state_e      st_q, st_d;
  logic [ORB_W-1:0] orb_q, orb_d;
  logic [BIN_W-1:0] caddr_q, caddr_d;
  logic             go;
  logic             marker;

  assign go     = run && fill_en;
  assign marker = xing && bc0;

  always_comb begin
    st_d    = st_q;
    orb_d   = orb_q;
    caddr_d = caddr_q;
    acc_en  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (clear_req) begin
          st_d    = ST_CLEAR;
          caddr_d = '0;
        end else if (go) begin
          st_d = ST_ARM;
        end
      end
      ST_ARM: begin
        if (!go) begin
          st_d = ST_IDLE;
        end else if (marker) begin
          st_d   = ST_FILL;
          orb_d  = ORB_W'(1);
          acc_en = 1'b1;
        end
      end
      ST_FILL: begin
        if (!go) begin
          st_d = ST_IDLE;
        end else if (xing) begin
          if (bc0 && (orb_q == ORB_LAST)) begin
            st_d = ST_DONE;
          end else begin
            acc_en = 1'b1;
            if (bc0) begin
              orb_d = orb_q + 1'b1;
            end
          end
        end
      end
      ST_DONE: begin
        if (clear_req) begin
          st_d    = ST_CLEAR;
          caddr_d = '0;
        end else if (!fill_en) begin
          st_d = ST_IDLE;
        end
      end
      ST_CLEAR: begin
        if (caddr_q == ADDR_MAX) begin
          st_d = ST_IDLE;
        end else begin
          caddr_d = caddr_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      orb_q   <= '0;
      caddr_q <= '0;
    end else begin
      st_q    <= st_d;
      orb_q   <= orb_d;
      caddr_q <= caddr_d;
    end
  end

  assign clr_en   = (st_q == ST_CLEAR);
  assign clr_addr = caddr_q;
  assign clearing = clr_en;
  assign done     = (st_q == ST_DONE);
  assign orb_cnt  = orb_q;
endmodule

// File: rtl/hist_bank.sv
module hist_bank #(
  parameter int BIN_W   = 12,
  parameter int CLASS_W = 6,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               acc_en,
  input  logic [BIN_W-1:0]   acc_addr,
  input  logic [CLASS_W-1:0] acc_val,
  input  logic               clr_en,
  input  logic [BIN_W-1:0]   clr_addr,
  input  logic [BIN_W-1:0]   rd_addr,
  output logic [CNT_W-1:0]   rd_data
);
  localparam int DEPTH = 1 << BIN_W;

  logic [CNT_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0] cur;
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] upd;

  always_comb begin
    cur = mem[acc_addr];
    sum = {1'b0, cur} + {{(CNT_W + 1 - CLASS_W){1'b0}}, acc_val};
    upd = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (clr_en) begin
      mem[clr_addr] <= '0;
    end else if (acc_en) begin
      mem[acc_addr] <= upd;
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/orbit_histogrammer.sv
module orbit_histogrammer #(
  parameter int BIN_W   = 12,
  parameter int CLASS_W = 6,
  parameter int CNT_W   = 16,
  parameter int ORBITS  = 1024,
  parameter int N_HIST  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      xing,
  input  logic                      bc0,
  input  logic [N_HIST*CLASS_W-1:0] cls_cnt,
  input  logic                      run,
  input  logic                      fill_en,
  input  logic                      clear_req,
  input  logic                      bin_wr,
  input  logic [BIN_W-1:0]          bin_in,
  input  logic [$clog2(N_HIST)-1:0] hist_sel,
  output logic [CNT_W-1:0]          rd_data,
  output logic                      done,
  output logic                      clearing
);
  localparam int ORB_W = $clog2(ORBITS + 1);

  logic [BIN_W-1:0] bx_q;
  logic [BIN_W-1:0] bin_now;
  logic             acc_en;
  logic             clr_en;
  logic [BIN_W-1:0] clr_addr;
  logic [ORB_W-1:0] orb_cnt;
  logic [BIN_W-1:0] rd_bin_q, rd_bin_d;
  logic [CNT_W-1:0] bank_q [N_HIST];

  hist_bunch_ctr #(.BIN_W(BIN_W)) u_bx (
    .clk     (clk),
    .rst_n   (rst_n),
    .xing    (xing),
    .bc0     (bc0),
    .bx_q    (bx_q),
    .bin_now (bin_now)
  );

  hist_fill_ctrl #(.BIN_W(BIN_W), .ORBITS(ORBITS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .xing      (xing),
    .bc0       (bc0),
    .run       (run),
    .fill_en   (fill_en),
    .clear_req (clear_req),
    .acc_en    (acc_en),
    .clr_en    (clr_en),
    .clr_addr  (clr_addr),
    .done      (done),
    .clearing  (clearing),
    .orb_cnt   (orb_cnt)
  );

  for (genvar k = 0; k < N_HIST; k++) begin : g_bank
    hist_bank #(.BIN_W(BIN_W), .CLASS_W(CLASS_W), .CNT_W(CNT_W)) u_bank (
      .clk      (clk),
      .acc_en   (acc_en),
      .acc_addr (bin_now),
      .acc_val  (cls_cnt[k*CLASS_W +: CLASS_W]),
      .clr_en   (clr_en),
      .clr_addr (clr_addr),
      .rd_addr  (rd_bin_q),
      .rd_data  (bank_q[k])
    );
  end

  always_comb begin
    rd_bin_d = bin_wr ? bin_in : rd_bin_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bin_q <= '0;
    end else begin
      rd_bin_q <= rd_bin_d;
    end
  end

  assign rd_data = bank_q[hist_sel];
endmodule

// File: rtl/hist_checker.sv
module hist_checker #(
  parameter int BIN_W  = 12,
  parameter int ORBITS = 1024
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        xing,
  input logic                        bc0,
  input logic                        run,
  input logic                        fill_en,
  input logic                        clear_req,
  input logic                        done,
  input logic                        clearing,
  input logic                        acc_en,
  input logic [BIN_W-1:0]            bx_q,
  input logic [$clog2(ORBITS+1)-1:0] orb_cnt
);
  localparam logic [BIN_W-1:0] BX_MAX = {BIN_W{1'b1}};

  assert_bx_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (xing && bc0) |=> (bx_q == '0));

  assert_bx_sat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (xing && !bc0 && bx_q == BX_MAX) |=> (bx_q == BX_MAX));

  assert_fill_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |-> (run && fill_en && xing));

  assert_done_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(xing && bc0 && run && fill_en && !acc_en));

  assert_orbit_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    orb_cnt <= ($clog2(ORBITS+1))'(ORBITS));

  assert_clear_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clearing |-> (!done && !acc_en));

  assert_clear_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && clear_req) |=> !clearing);
endmodule

bind orbit_histogrammer hist_checker #(.BIN_W(BIN_W), .ORBITS(ORBITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .xing      (xing),
  .bc0       (bc0),
  .run       (run),
  .fill_en   (fill_en),
  .clear_req (clear_req),
  .done      (done),
  .clearing  (clearing),
  .acc_en    (acc_en),
  .bx_q      (bx_q),
  .orb_cnt   (orb_cnt)
);

// File: tb/orbit_histogrammer_bench.sv
`timescale 1ns/1ps
module orbit_histogrammer_bench;
  localparam int BW   = 4;
  localparam int CW   = 4;
  localparam int NW   = 6;
  localparam int ORB  = 3;
  localparam int NB   = 1 << BW;
  localparam int BMAX = NB - 1;
  localparam int VMAX = (1 << NW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          xing, bc0, run, fill_en, clear_req, bin_wr;
  logic [4*CW-1:0] cls_cnt;
  logic [BW-1:0] bin_in;
  logic [1:0]    hist_sel;
  logic [NW-1:0] rd_data;
  logic          done, clearing;

  orbit_histogrammer #(.BIN_W(BW), .CLASS_W(CW), .CNT_W(NW), .ORBITS(ORB), .N_HIST(4))
  u_orbit_histogrammer (
    .clk(clk), .rst_n(rst_n), .xing(xing), .bc0(bc0), .cls_cnt(cls_cnt),
    .run(run), .fill_en(fill_en), .clear_req(clear_req), .bin_wr(bin_wr),
    .bin_in(bin_in), .hist_sel(hist_sel), .rd_data(rd_data), .done(done),
    .clearing(clearing)
  );

  always #2.5 clk = ~clk;

  int    n_vec = 0;
  int    n_bad = 0;
  int    cycles = 0;
  string tag = "R1";

  // behavioural reference: 0 idle, 1 waiting for marker, 2 filling, 3 done, 4 clearing
  int m_st, m_bx, m_orb, m_ca, m_bin;
  int mdl [4][NB];
  bit m_valid;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_bx = 0; m_orb = 0; m_ca = 0; m_bin = 0;
    end else begin
      int  nb;
      bit  go, add;
      go  = run && fill_en;
      add = 1'b0;
      nb  = bc0 ? 0 : ((m_bx == BMAX) ? BMAX : m_bx + 1);
      case (m_st)
        0: if (clear_req) begin m_st = 4; m_ca = 0; end
           else if (go) m_st = 1;
        1: if (!go) m_st = 0;
           else if (xing && bc0) begin m_st = 2; m_orb = 1; add = 1'b1; end
        2: if (!go) m_st = 0;
           else if (xing) begin
             if (bc0 && m_orb == ORB) m_st = 3;
             else begin add = 1'b1; if (bc0) m_orb++; end
           end
        3: if (clear_req) begin m_st = 4; m_ca = 0; end
           else if (!fill_en) m_st = 0;
        default: begin
          for (int k = 0; k < 4; k++) mdl[k][m_ca] = 0;
          if (m_ca == BMAX) begin m_st = 0; m_valid = 1'b1; end
          else m_ca++;
        end
      endcase
      if (add) begin
        for (int k = 0; k < 4; k++) begin
          int v;
          v = mdl[k][nb] + int'(cls_cnt[k*CW +: CW]);
          mdl[k][nb] = (v > VMAX) ? VMAX : v;
        end
      end
      if (xing) m_bx = nb;
      if (bin_wr) m_bin = int'(bin_in);
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      n_vec++;
      if (done !== (m_st == 3)) begin
        n_bad++;
        $display("FAIL %s done: actual %0b expected %0b", tag, done, (m_st == 3));
      end
      n_vec++;
      if (clearing !== (m_st == 4)) begin
        n_bad++;
        $display("FAIL %s clearing: actual %0b expected %0b", tag, clearing, (m_st == 4));
      end
      if (m_valid) begin
        n_vec++;
        if (int'(rd_data) !== mdl[hist_sel][m_bin]) begin
          n_bad++;
          $display("FAIL %s hist %0d bin %0d: actual %0d expected %0d",
                   tag, hist_sel, m_bin, rd_data, mdl[hist_sel][m_bin]);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic orbit(input int n, input int seed, input int gap, input bit mark);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      xing = 1'b1;
      bc0  = mark && (i == 0);
      for (int k = 0; k < 4; k++) cls_cnt[k*CW +: CW] = CW'((i * 3 + k * 5 + seed) % 16);
      if (gap > 0 && (i % gap) == gap - 1) begin
        @(negedge clk);
        xing = 1'b0; bc0 = 1'b0;
      end
    end
    @(negedge clk);
    xing = 1'b0; bc0 = 1'b0;
  endtask

  task automatic sweep();
    for (int b = 0; b < NB; b++) begin
      @(negedge clk);
      bin_wr = 1'b1; bin_in = BW'(b);
      @(negedge clk);
      bin_wr = 1'b0;
      for (int s = 0; s < 4; s++) begin
        hist_sel = 2'(s);
        @(negedge clk);
      end
    end
  endtask

  task automatic do_clear();
    @(negedge clk); clear_req = 1'b1;
    @(negedge clk); clear_req = 1'b0;
    repeat (NB + 2) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; xing = 0; bc0 = 0; run = 0; fill_en = 0; clear_req = 0;
    bin_wr = 0; bin_in = '0; hist_sel = '0; cls_cnt = '0;
    m_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";
    orbit(6, 1, 0, 1'b1);
    repeat (3) @(negedge clk);

    tag = "R8";
    do_clear();
    tag = "R9";
    sweep();

    tag = "R3";
    run = 1'b1;
    orbit(10, 2, 0, 1'b1);
    @(negedge clk); fill_en = 1'b1;
    orbit(5, 3, 2, 1'b0);
    tag = "R4";
    orbit(12, 4, 3, 1'b1);
    orbit(9, 5, 0, 1'b1);
    tag = "R6";
    orbit(11, 6, 4, 1'b1);
    orbit(12, 7, 0, 1'b1);
    repeat (4) @(negedge clk);
    fill_en = 1'b0;
    repeat (3) @(negedge clk);
    tag = "R4";
    sweep();

    tag = "R8";
    @(negedge clk); fill_en = 1'b1;
    repeat (2) @(negedge clk);
    orbit(3, 8, 0, 1'b1);
    do_clear();
    fill_en = 1'b0;
    repeat (2) @(negedge clk);
    do_clear();
    tag = "R10";
    fill_en = 1'b1;
    orbit(6, 9, 0, 1'b1);
    @(negedge clk); xing = 1'b1; clear_req = 1'b1;
    @(negedge clk); xing = 1'b0; clear_req = 1'b0;
    orbit(4, 10, 0, 1'b1);
    tag = "R7";
    orbit(3, 11, 0, 1'b1);
    @(negedge clk); run = 1'b0;
    orbit(7, 12, 0, 1'b0);
    orbit(7, 13, 0, 1'b1);
    fill_en = 1'b0;
    tag = "R9";
    sweep();

    tag = "R2";
    run = 1'b1; fill_en = 1'b1;
    repeat (2) @(negedge clk);
    orbit(22, 15, 0, 1'b1);
    tag = "R5";
    orbit(22, 15, 5, 1'b1);
    orbit(21, 15, 0, 1'b1);
    orbit(4, 0, 0, 1'b1);
    fill_en = 1'b0;
    repeat (2) @(negedge clk);
    sweep();

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule